// File: doc/BRIEF.md
# External Interrupt Request Controller

This block serves one interrupt source driven from an external pin. It brings the pin into the clock domain through a synchroniser, detects the edge selected by software, and records it in a sticky request flag. Software sees one 8-bit control register on a simple synchronous bus. The register holds a 3-bit priority, the request flag, an edge polarity select and one reserved bit. A separate both-edges select input can make either edge of the pin count.

The block presents a request and its priority to a downstream arbiter. The request is raised only when the flag is set and the priority is nonzero, so a priority of zero masks the source. Edges are still recorded while the source is masked. The arbiter pulses an acknowledge input to clear the flag when it accepts the interrupt. Software can also clear the flag by writing 0 to it, but no write can set it. An edge that arrives in the same cycle as a clear wins.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset the control register reads 0x00 and `irqReq` is 0.
- R2: A bus write stores `busWdata[2:0]` as the priority. The priority reads back on `busRdata[2:0]` and drives `irqLevel` from the next cycle.
- R3: The request flag sits at bit 3 (1 = pending). It is set by a selected pin edge and by nothing else.
- R4: Writing 0 to bit 3 clears the flag. Writing 1 to bit 3 leaves the flag unchanged.
- R5: Bit 4 selects the polarity: 0 detects falling edges and 1 detects rising edges. An edge of the other direction does not set the flag.
- R6: While `bothEdges` is 1, both rising and falling pin edges set the flag, whatever the value of bit 4.
- R7: Bit 5 stores and reads back the written value. Bits 7:6 always read as 0.
- R8: `irqReq` is 1 exactly when the flag is 1 and the priority is nonzero. While the priority is 0 the flag still latches edges, and `irqReq` rises once a nonzero priority is written.
- R9: An `irqAck` pulse clears the flag on the next clock edge.
- R10: If a pin edge is detected in the same cycle as a software clear or an acknowledge, the flag ends up set.
- R11: A pin change driven between clock edges shows in the flag after exactly three rising clock edges: two synchroniser stages, then the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register select |
| busWe | input | 1 | Write enable, qualified by busSel |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Register contents, always driven |
| extPin | input | 1 | Asynchronous external interrupt pin |
| bothEdges | input | 1 | 1 = both pin edges raise a request |
| irqAck | input | 1 | Acknowledge pulse from the arbiter |
| irqReq | output | 1 | Request to the arbiter |
| irqLevel | output | 3 | Priority sent with the request |

## Verification
A wrong flag state shows up on two ports, `busRdata[3]` and `irqReq`, in the cycle after the clock edge that corrupted it. An edge that was lost or wrongly counted therefore appears three clock edges after the pin moves. A wrong polarity or both-edges decode shows as a flag that stays 0 when it should be set, or that is set on the wrong edge. The bench checks edges that must be ignored several cycles after the pin moves, so it can tell a lost edge from a late one. The collision cases are timed so that the detected edge and the clear land on the same clock edge, which exposes a wrong priority between set and clear.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int REG_W   = 8;
  localparam int LEVEL_W = 3;

  localparam int FLAG_BIT = 3;
  localparam int POL_BIT  = 4;
  localparam int RSVD_BIT = 5;

  typedef struct packed {
    logic wrCfg;    // update priority, polarity and reserved bit
    logic clrFlag;  // software wrote 0 to the flag
    logic ackFlag;  // arbiter accepted the request
    logic setFlag;  // a selected edge was detected
  } ctlStrobe_t;

endpackage

// File: rtl/irq_ctl_control.sv
module irq_ctl_control
  import irq_ctl_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWe,
  input  logic       wrFlagBit,
  input  logic       extPin,
  input  logic       bothEdges,
  input  logic       polRise,
  input  logic       irqAck,
  output logic       edgeHit,
  output ctlStrobe_t strobes
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   pinNow;
  logic                   riseSeen;
  logic                   fallSeen;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= PIN_IDLE;
        else       syncQ[i] <= extPin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= PIN_IDLE;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= PIN_IDLE;
    else       prevQ <= pinNow;
  end

  assign riseSeen = pinNow & ~prevQ;
  assign fallSeen = ~pinNow & prevQ;

  always_comb begin
    if (bothEdges)    edgeHit = riseSeen | fallSeen;
    else if (polRise) edgeHit = riseSeen;
    else              edgeHit = fallSeen;
  end

  always_comb begin
    strobes.wrCfg   = busSel & busWe;
    strobes.clrFlag = busSel & busWe & ~wrFlagBit;
    strobes.ackFlag = irqAck;
    strobes.setFlag = edgeHit;
  end

endmodule

// File: rtl/irq_ctl_datapath.sv
module irq_ctl_datapath
  import irq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobes,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic               polRise,
  output logic               irqReq,
  output logic [LEVEL_W-1:0] irqLevel
);

  logic [LEVEL_W-1:0] levelQ;
  logic               flagQ;
  logic               polQ;
  logic               rsvdQ;
  logic [1:0]         unusedHi;

  assign unusedHi = wrData[REG_W-1:REG_W-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      polQ   <= 1'b0;
      rsvdQ  <= 1'b0;
    end else if (strobes.wrCfg) begin
      levelQ <= wrData[LEVEL_W-1:0];
      polQ   <= wrData[POL_BIT];
      rsvdQ  <= wrData[RSVD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   flagQ <= 1'b0;
    else if (strobes.setFlag)                    flagQ <= 1'b1;
    else if (strobes.clrFlag || strobes.ackFlag) flagQ <= 1'b0;
  end

  always_comb begin
    rdData                 = '0;
    rdData[LEVEL_W-1:0]    = levelQ;
    rdData[FLAG_BIT]       = flagQ;
    rdData[POL_BIT]        = polQ;
    rdData[RSVD_BIT]       = rsvdQ;
  end

  assign polRise  = polQ;
  assign irqLevel = levelQ;
  assign irqReq   = flagQ & (|levelQ);

endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
  import irq_ctl_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]   busRdata,
  input  logic               extPin,
  input  logic               bothEdges,
  input  logic               irqAck,
  output logic               irqReq,
  output logic [LEVEL_W-1:0] irqLevel
);

  ctlStrobe_t strobes;
  logic       polRise;
  logic       edgeHit;

  irq_ctl_control #(
    .SYNC_STAGES(SYNC_STAGES),
    .PIN_IDLE   (PIN_IDLE)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWe    (busWe),
    .wrFlagBit(busWdata[FLAG_BIT]),
    .extPin   (extPin),
    .bothEdges(bothEdges),
    .polRise  (polRise),
    .irqAck   (irqAck),
    .edgeHit  (edgeHit),
    .strobes  (strobes)
  );

  irq_ctl_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWdata),
    .rdData  (busRdata),
    .polRise (polRise),
    .irqReq  (irqReq),
    .irqLevel(irqLevel)
  );

endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWe,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       irqAck,
  input logic       irqReq,
  input logic [2:0] irqLevel,
  input logic       edgeHit
);

  // R2: a write sets the priority seen by the arbiter
  assert_level_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe) |=> (irqLevel == $past(busWdata[2:0])));

  // R3: the flag never rises without a detected edge
  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdata[3] && !edgeHit) |=> !busRdata[3]);

  // R4: writing 1 to the flag never clears it
  assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busWdata[3] && !irqAck && busRdata[3]) |=> busRdata[3]);

  // R7: the unassigned bits read as zero
  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[7:6] == 2'b00);

  // R8: a zero priority masks the request
  assert_level_zero_masks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == 3'd0) |-> !irqReq);

  // R9: an acknowledge without a new edge clears the flag
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !edgeHit) |=> !busRdata[3]);

  // R10: a detected edge always leaves the flag set
  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> busRdata[3]);

endmodule

bind irq_ctl_unit irq_ctl_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWe   (busWe),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .irqAck  (irqAck),
  .irqReq  (irqReq),
  .irqLevel(irqLevel),
  .edgeHit (edgeHit)
);

// File: tb/irq_ctl_unit_bench.sv
module irq_ctl_unit_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       extPin = 1'b1;
  logic       bothEdges = 1'b0;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic [2:0] irqLevel;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] expData;
    logic       expReq;
  } expItem_t;

  expItem_t sbQueue[$];

  always #2 clk = ~clk;  // 250 MHz

  irq_ctl_unit u_irq_ctl_unit (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .extPin   (extPin),
    .bothEdges(bothEdges),
    .irqAck   (irqAck),
    .irqReq   (irqReq),
    .irqLevel (irqLevel)
  );

  // Monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      wait (sbQueue.size() > 0);
      begin
        expItem_t it;
        it = sbQueue.pop_front();
        vectors++;
        if (busRdata !== it.expData || irqReq !== it.expReq) begin
          errors++;
          $display("FAIL %s: rdata=%02h req=%b expected rdata=%02h req=%b",
                   it.tag, busRdata, irqReq, it.expData, it.expReq);
        end
      end
    end
  end

  task automatic expectNow(input string tag, input logic [7:0] d, input logic r);
    expItem_t it;
    it.tag = tag; it.expData = d; it.expReq = r;
    sbQueue.push_back(it);
    #1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] d);
    busSel = 1'b1; busWe = 1'b1; busWdata = d;
    step(1);
    busSel = 1'b0; busWe = 1'b0; busWdata = 8'h00;
  endtask

  task automatic ackPulse();
    irqAck = 1'b1;
    step(1);
    irqAck = 1'b0;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    expectNow("R1 reset", 8'h00, 1'b0);

    regWrite(8'h05);
    expectNow("R2 level write", 8'h05, 1'b0);

    extPin = 1'b0;                                   // falling, pol=0
    step(2);
    expectNow("R11 not yet after two edges", 8'h05, 1'b0);
    step(1);
    expectNow("R3 R11 R8 falling sets flag", 8'h0D, 1'b1);

    regWrite(8'h0D);
    expectNow("R4 write one keeps flag", 8'h0D, 1'b1);
    regWrite(8'h05);
    expectNow("R4 write zero clears flag", 8'h05, 1'b0);

    extPin = 1'b1;                                   // rising ignored, pol=0
    step(4);
    expectNow("R5 rising ignored with pol 0", 8'h05, 1'b0);

    regWrite(8'h13);                                 // pol=1, level 3
    extPin = 1'b0;
    step(4);
    expectNow("R5 falling ignored with pol 1", 8'h13, 1'b0);
    extPin = 1'b1;
    step(3);
    expectNow("R5 rising sets with pol 1", 8'h1B, 1'b1);

    ackPulse();
    expectNow("R9 ack clears flag", 8'h13, 1'b0);

    bothEdges = 1'b1;
    regWrite(8'h02);
    extPin = 1'b0;
    step(3);
    expectNow("R6 both edges falling", 8'h0A, 1'b1);
    ackPulse();
    expectNow("R9 ack clears again", 8'h02, 1'b0);
    extPin = 1'b1;
    step(3);
    expectNow("R6 both edges rising with pol 0", 8'h0A, 1'b1);
    ackPulse();

    regWrite(8'h00);
    expectNow("R8 level zero writes", 8'h00, 1'b0);
    extPin = 1'b0;
    step(3);
    expectNow("R8 masked but latched", 8'h08, 1'b0);
    regWrite(8'h0E);
    expectNow("R8 unmask raises request", 8'h0E, 1'b1);
    expect_irqLevel: if (irqLevel !== 3'd6) begin
      errors++;
      $display("FAIL R2 irqLevel=%0d expected 6", irqLevel);
    end
    vectors++;

    regWrite(8'hE4);
    expectNow("R7 reserved kept, top bits zero", 8'h24, 1'b0);

    extPin = 1'b1;
    step(3);
    expectNow("R6 flag set before collision", 8'h2C, 1'b1);
    extPin = 1'b0;                                   // edge detected on third posedge
    step(2);
    busSel = 1'b1; busWe = 1'b1; busWdata = 8'h24; irqAck = 1'b1;
    step(1);
    busSel = 1'b0; busWe = 1'b0; busWdata = 8'h00; irqAck = 1'b0;
    expectNow("R10 edge beats clear and ack", 8'h2C, 1'b1);
    ackPulse();
    expectNow("R9 ack alone clears", 8'h24, 1'b0);

    step(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule